// File: doc/BRIEF.md
# Free-Running Timer with Deferred-Load Compare Channel

This block is a free-running up-counter with a single compare channel. The counter advances only on cycles where an external count-enable strobe (typically a prescaler tick) is high. It wraps from its all-ones value back to zero. Software programs the compare value over a small write-only register port. The written value lands in a one-entry staging slot and is not used for matching until the counter next advances. While a staged value is waiting, further compare writes are thrown away. Software detects that its value has been applied by watching the pending bit, or the active-compare readback, change.

A match is an exact-equality event: it fires on a count-enable cycle in which the counter holds exactly the active compare value. A compare value set behind the current count therefore produces nothing until the counter wraps around and reaches it. A match sets a sticky flag, which software clears by writing 1. The flag drives a level interrupt while the interrupt-enable bit is set. The register port is plain control, with no back-pressure: a write is taken in the cycle its strobe is high, and the block decides whether to keep or drop it.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset, count_o, active_cmp_o, pend_o, flag_o and irq_o are all zero, and the interrupt enable is cleared.
- R2: The counter is CNT_W bits wide (default 32). It increases by one at each clock edge where tick_en is high, holds when tick_en is low, and rolls from all ones to zero.
- R3: A write with reg_addr = 0 while pend_o is low is captured in the staging slot, and pend_o reads 1 after that edge. active_cmp_o does not change until a later tick.
- R4: While pend_o is high, the first edge with tick_en high copies the staged value into active_cmp_o and clears pend_o at the same edge. A compare write therefore takes effect within one count period.
- R5: A write with reg_addr = 0 while pend_o is high is discarded. The value later applied is the first, accepted one.
- R6: At an edge where tick_en is high and count_o equals active_cmp_o, flag_o is set. No other condition sets it, so a compare value that the count has already passed gives no event until after the counter wraps.
- R7: flag_o stays set until a write with reg_addr = 2 and bit 0 of the data at 1. A write to that address with bit 0 at 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R8: A write with reg_addr = 1 loads bit 0 of the data as the interrupt enable. irq_o is high exactly when flag_o and the enable are both set. Writes with reg_addr = 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-enable strobe from the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 compare, 1 control, 2 status clear, 3 reserved |
| reg_wdata | input | CNT_W | Write data |
| count_o | output | CNT_W | Counter readback |
| active_cmp_o | output | CNT_W | Active compare readback |
| pend_o | output | 1 | Staged compare value waiting for a tick |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench writes twice to the compare register inside one count period. A design that let the second write overwrite the slot would apply 9 instead of 5. It then programs a compare value behind the running count and walks the counter through a full wrap. A design that matched on greater-or-equal would raise the flag at once, and one that never wrapped would never raise it. Random traffic places compare values near the count, so that writes arrive on the same edge as the tick that applies the staged value, and clears coincide with matches. A design that gave the clear priority, or that applied a dropped write, would then differ from the bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_CMP  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (tick_i) count_q <= count_q + ONE;
  end

  assign count_o = count_q;

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_o));

  // R2
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && count_o == TOP) |=> count_o == '0);
endmodule

// File: rtl/tmr_cmp_buffer.sv
module tmr_cmp_buffer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] active_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] staged_q;
  logic [CNT_W-1:0] active_q;
  logic             pend_q;
  logic             apply;
  logic             accept;

  assign apply  = pend_q && tick_i;
  assign accept = wr_i && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
    end else if (apply) begin
      active_q <= staged_q;
      pend_q   <= 1'b0;
    end else if (accept) begin
      staged_q <= wdata_i;
      pend_q   <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign pend_o   = pend_q;

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_o && tick_i) |=> $stable(active_o));

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && tick_i) |=> !pend_o);

  // R5
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !tick_i) |=> pend_o);
endmodule

// File: rtl/tmr_match_flag.sv
module tmr_match_flag #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] active_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic hit;
  logic flag_q;

  assign hit = tick_i && (count_i == active_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(tick_i && count_i == active_i));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] active_cmp_o,
  output logic             pend_o,
  output logic             flag_o,
  output logic             irq_o
);
  import tmr_pkg::*;

  logic cmp_wr;
  logic ctrl_wr;
  logic flag_clr;
  logic ien_q;

  assign cmp_wr   = reg_wr && (reg_addr == ADDR_CMP);
  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
  assign flag_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (ctrl_wr) ien_q <= reg_wdata[0];
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .count_o(count_o)
  );

  tmr_cmp_buffer #(.CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .wr_i(cmp_wr),
    .wdata_i(reg_wdata), .active_o(active_cmp_o), .pend_o(pend_o)
  );

  tmr_match_flag #(.CNT_W(CNT_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .count_i(count_o),
    .active_i(active_cmp_o), .clr_i(flag_clr), .flag_o(flag_o)
  );

  assign irq_o = flag_o && ien_q;

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[0]) |=> !irq_o);
endmodule

// File: tb/tick_compare_timer_bench.sv
module tick_compare_timer_bench;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] count_o, active_cmp_o;
  logic         pend_o, flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_cnt, m_act, m_stg;
  logic         m_pend, m_flag, m_ien;

  always #2.5 clk = ~clk;

  tick_compare_timer #(.CNT_W(W)) u_tick_compare_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .count_o(count_o),
    .active_cmp_o(active_cmp_o), .pend_o(pend_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "count", 32'(count_o), 32'(m_cnt));
    chk(tag, "active", 32'(active_cmp_o), 32'(m_act));
    chk(tag, "pend", 32'(pend_o), 32'(m_pend));
    chk(tag, "flag", 32'(flag_o), 32'(m_flag));
    chk(tag, "irq", 32'(irq_o), 32'(m_flag && m_ien));
  endtask

  // One clock: drive at the falling edge, update the model, compare at the next falling edge
  task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [W-1:0] d, input string tag);
    logic hit, clr;
    logic [W-1:0] n_act, n_stg;
    logic n_pend, n_flag, n_ien;
    tick_en = t; reg_wr = w; reg_addr = a; reg_wdata = d;
    hit = t && (m_cnt == m_act);
    clr = w && a == 2'd2 && d[0];
    n_flag = hit ? 1'b1 : (clr ? 1'b0 : m_flag);
    n_ien = (w && a == 2'd1) ? d[0] : m_ien;
    n_act = m_act; n_stg = m_stg; n_pend = m_pend;
    if (m_pend && t) begin n_act = m_stg; n_pend = 1'b0; end
    else if (w && a == 2'd0 && !m_pend) begin n_stg = d; n_pend = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    if (t) m_cnt = m_cnt + W'(1);
    m_act = n_act; m_stg = n_stg; m_pend = n_pend; m_flag = n_flag; m_ien = n_ien;
    tick_en = 1'b0; reg_wr = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = '0; m_act = '0; m_stg = '0; m_pend = 0; m_flag = 0; m_ien = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_all("R1");

    // R8 enable interrupt; R3 first write staged, active unchanged
    step(0, 1, 2'd1, W'(1), "R8");
    step(0, 1, 2'd0, W'(5), "R3");
    chk("R3", "pend set", 32'(pend_o), 32'd1);
    chk("R3", "active unchanged", 32'(active_cmp_o), 32'd0);
    // R5 second write in the same period is dropped
    step(0, 1, 2'd0, W'(9), "R5");
    step(1, 0, 2'd0, '0, "R4");
    chk("R5", "applied value", 32'(active_cmp_o), 32'd5);
    chk("R4", "pend cleared", 32'(pend_o), 32'd0);
    // R6 count 0 == active 0 at that tick, so the flag rose
    chk("R6", "flag on equality", 32'(flag_o), 32'd1);
    // R7 clear with bit0=0 is ignored, then a real clear
    step(0, 1, 2'd2, W'(0), "R7");
    chk("R7", "flag kept", 32'(flag_o), 32'd1);
    chk("R8", "irq with enable", 32'(irq_o), 32'd1);
    step(0, 1, 2'd3, W'(1), "R8");
    chk("R8", "reserved addr no effect", 32'(flag_o), 32'd1);
    step(0, 1, 2'd1, W'(0), "R8");
    chk("R8", "irq gated", 32'(irq_o), 32'd0);
    step(0, 1, 2'd2, W'(1), "R7");
    chk("R7", "flag cleared", 32'(flag_o), 32'd0);
    step(0, 1, 2'd1, W'(1), "R8");

    // R6 compare set behind the count: no event until after the wrap
    while (m_cnt != W'(20)) step(1, 0, 2'd0, '0, "R2");
    step(0, 1, 2'd0, W'(10), "R6");
    while (m_pend) step(1, 0, 2'd0, '0, "R4");
    step(0, 1, 2'd2, W'(1), "R7");
    while (m_cnt != W'(10)) begin
      step(1, 0, 2'd0, '0, "R2");
      chk("R6", "no early event", 32'(flag_o), 32'd0);
    end
    step(1, 0, 2'd0, '0, "R6");
    chk("R6", "event after wrap", 32'(flag_o), 32'd1);

    // Constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic t, w;
      logic [1:0] a;
      logic [W-1:0] d;
      t = ($urandom % 3) != 0;
      w = ($urandom % 3) == 0;
      a = 2'($urandom % 4);
      d = ($urandom % 2) ? m_cnt + W'($urandom % 4) : W'($urandom);
      if (a == 2'd2 && ($urandom % 2)) d[0] = 1'b1;
      step(t, w, a, d, "R2 R3 R4 R5 R6 R7 R8");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule